// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit decides where a 32-bit RISC core with one branch delay slot fetches after a control-transfer instruction, and which return address, if any, it writes back. The decoder hands it a control kind, the address of the control instruction, two register operands, a 16-bit word offset, a 26-bit jump field and a link destination index. One clock later the unit presents the chosen next address, a taken flag, a link-write enable, the link destination and the link value.

Conditional branches come in two groups. The first compares two registers for equality or inequality. The second tests one register against zero as a signed number, and two of those tests also write a return address. Absolute jumps replace the low 28 bits of the sequential address and keep its top four bits. Register-indirect jumps take the first operand as the target, and their linking form writes to a caller-chosen register. Fetch, execution of the delay slot and alignment traps are handled elsewhere.

Control kinds are the decode states of the unit: `K_SEQ` is ordinary sequential flow; `K_EQ`, `K_NE`, `K_LEZ`, `K_GTZ`, `K_LTZ`, `K_GEZ`, `K_LTZ_LNK` and `K_GEZ_LNK` are the branches; `K_JMP`, `K_JMP_LNK`, `K_JIND` and `K_JIND_LNK` are the jumps. Each accepted request moves from its kind to one of two outcomes, taken (go to the computed target) or fall-through (go to PC+4).

Top module: `npc_unit`

## Requirements
- R1: With `in_kind` 1 (`K_EQ`) the branch is taken when `in_opa` equals `in_opb`; with `in_kind` 2 (`K_NE`) it is taken when they differ.
- R2: Kinds 3 to 6 test `in_opa` as a signed value against zero: 3 less-or-equal, 4 greater-than, 5 less-than, 6 greater-or-equal.
- R3: A taken branch goes to PC+4 plus the sign-extended `in_off` shifted left by two; a conditional branch that is not taken goes to PC+4 with `out_taken` low.
- R4: Kinds 9 (`K_JMP`) and 10 (`K_JMP_LNK`) are always taken to {PC+4 bits 31..28, `in_tgt`, 2'b00}, so the top four bits come from PC+4 even when PC+4 lies in a new 256 MB region.
- R5: Kind 10 raises `out_link_we` with destination 31 and link value PC+8.
- R6: Kind 11 (`K_JIND`) and kind 12 (`K_JIND_LNK`) are always taken to `in_opa`; kind 12 writes PC+8 to the register index given on `in_link_rd`.
- R7: Kind 7 (`K_LTZ_LNK`, taken when `in_opa` is negative) and kind 8 (`K_GEZ_LNK`, taken when it is non-negative) write PC+8 to register 31 whether or not the branch is taken.
- R8: Kind 0 and the unused codes 13 to 15 give PC+4, `out_taken` low and `out_link_we` low.
- R9: A request accepted with `in_valid` high at a rising edge appears on the outputs after that edge with `out_valid` high; a cycle without `in_valid` gives `out_valid` low. After reset all outputs are zero.
- R10: Whenever `out_link_we` is low, `out_link_dst` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 4 | Control kind code |
| in_pc | input | 32 | Address of the control instruction |
| in_opa | input | 32 | First register operand |
| in_opb | input | 32 | Second register operand |
| in_off | input | 16 | Branch word offset |
| in_tgt | input | 26 | Absolute jump word field |
| in_link_rd | input | 5 | Link destination for indirect link jump |
| out_valid | output | 1 | Result present |
| out_next_pc | output | 32 | Next fetch address |
| out_taken | output | 1 | Control transfer taken |
| out_link_we | output | 1 | Return address write enable |
| out_link_dst | output | 5 | Return address register index |
| out_link_val | output | 32 | Return address value |

## Verification
The hardest cases to reach from the ports are the ones where two rules meet: an absolute jump whose PC+4 has just crossed into the next 256 MB region, a linking branch that falls through yet must still write its return register, and the signed zero tests at the extremes 0, -1 and the most negative value. The stimulus places the control instruction at 0xAFFFFFFC and 0xFFFFFFFC to force the carry into the top bits, and drives each linking branch with operands on both sides of zero. Back-to-back requests and an idle gap check that results line up with their requests.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        K_SEQ      = 4'd0,
        K_EQ       = 4'd1,
        K_NE       = 4'd2,
        K_LEZ      = 4'd3,
        K_GTZ      = 4'd4,
        K_LTZ      = 4'd5,
        K_GEZ      = 4'd6,
        K_LTZ_LNK  = 4'd7,
        K_GEZ_LNK  = 4'd8,
        K_JMP      = 4'd9,
        K_JMP_LNK  = 4'd10,
        K_JIND     = 4'd11,
        K_JIND_LNK = 4'd12
    } ctl_kind_e;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctl_kind_e        kind,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic             cond_hit
);

    logic is_neg;
    logic is_zero;
    logic is_same;

    assign is_neg  = opa[XLEN-1];
    assign is_zero = (opa == '0);
    assign is_same = (opa == opb);

    always_comb begin
        unique case (kind)
            K_EQ:                    cond_hit = is_same;
            K_NE:                    cond_hit = !is_same;
            K_LEZ:                   cond_hit = is_neg || is_zero;
            K_GTZ:                   cond_hit = !is_neg && !is_zero;
            K_LTZ, K_LTZ_LNK:        cond_hit = is_neg;
            K_GEZ, K_GEZ_LNK:        cond_hit = !is_neg;
            K_JMP, K_JMP_LNK,
            K_JIND, K_JIND_LNK:      cond_hit = 1'b1;
            default:                 cond_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int TGT_W = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  opa,
    input  logic [OFF_W-1:0] off,
    input  logic [TGT_W-1:0] tgt,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt,
    output logic [XLEN-1:0]  ind_tgt,
    output logic [XLEN-1:0]  link_val
);

    localparam int SEXT_W   = XLEN - OFF_W - 2;
    localparam int REGION_W = XLEN - TGT_W - 2;

    logic [XLEN-1:0] off_bytes;

    assign seq_pc    = pc + XLEN'(4);
    assign link_val  = pc + XLEN'(8);
    assign off_bytes = {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};
    assign br_tgt    = seq_pc + off_bytes;
    assign jmp_tgt   = {seq_pc[XLEN-1 -: REGION_W], tgt, 2'b00};
    assign ind_tgt   = opa;

endmodule

// File: rtl/npc_route.sv
module npc_route
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IDX_W  = 5,
    parameter int RA_IDX = 31
) (
    input  ctl_kind_e        kind,
    input  logic             cond_hit,
    input  logic [XLEN-1:0]  seq_pc,
    input  logic [XLEN-1:0]  br_tgt,
    input  logic [XLEN-1:0]  jmp_tgt,
    input  logic [XLEN-1:0]  ind_tgt,
    input  logic [IDX_W-1:0] link_rd,
    output logic [XLEN-1:0]  nxt_pc,
    output logic             take,
    output logic             lwe,
    output logic [IDX_W-1:0] ldst
);

    localparam logic [IDX_W-1:0] RA = IDX_W'(RA_IDX);

    logic [XLEN-1:0] tgt_sel;

    always_comb begin
        tgt_sel = seq_pc;
        take    = 1'b0;
        lwe     = 1'b0;
        ldst    = '0;
        unique case (kind)
            K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ: begin
                tgt_sel = br_tgt;
                take    = cond_hit;
            end
            K_LTZ_LNK, K_GEZ_LNK: begin
                tgt_sel = br_tgt;
                take    = cond_hit;
                lwe     = 1'b1;
                ldst    = RA;
            end
            K_JMP: begin
                tgt_sel = jmp_tgt;
                take    = 1'b1;
            end
            K_JMP_LNK: begin
                tgt_sel = jmp_tgt;
                take    = 1'b1;
                lwe     = 1'b1;
                ldst    = RA;
            end
            K_JIND: begin
                tgt_sel = ind_tgt;
                take    = 1'b1;
            end
            K_JIND_LNK: begin
                tgt_sel = ind_tgt;
                take    = 1'b1;
                lwe     = 1'b1;
                ldst    = link_rd;
            end
            default: begin
                tgt_sel = seq_pc;
            end
        endcase
        nxt_pc = take ? tgt_sel : seq_pc;
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int TGT_W  = 26,
    parameter int IDX_W  = 5,
    parameter int RA_IDX = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_kind,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [XLEN-1:0]   in_opa,
    input  logic [XLEN-1:0]   in_opb,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [TGT_W-1:0]  in_tgt,
    input  logic [IDX_W-1:0]  in_link_rd,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_next_pc,
    output logic              out_taken,
    output logic              out_link_we,
    output logic [IDX_W-1:0]  out_link_dst,
    output logic [XLEN-1:0]   out_link_val
);

    ctl_kind_e        kind_e;
    logic             cond_hit;
    logic [XLEN-1:0]  seq_pc;
    logic [XLEN-1:0]  br_tgt;
    logic [XLEN-1:0]  jmp_tgt;
    logic [XLEN-1:0]  ind_tgt;
    logic [XLEN-1:0]  link_val;
    logic [XLEN-1:0]  nxt_pc;
    logic             take;
    logic             lwe;
    logic [IDX_W-1:0] ldst;

    assign kind_e = ctl_kind_e'(in_kind);

    npc_cond_eval #(.XLEN(XLEN)) u_cond (
        .kind     (kind_e),
        .opa      (in_opa),
        .opb      (in_opb),
        .cond_hit (cond_hit)
    );

    npc_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_tgt (
        .pc       (in_pc),
        .opa      (in_opa),
        .off      (in_off),
        .tgt      (in_tgt),
        .seq_pc   (seq_pc),
        .br_tgt   (br_tgt),
        .jmp_tgt  (jmp_tgt),
        .ind_tgt  (ind_tgt),
        .link_val (link_val)
    );

    npc_route #(.XLEN(XLEN), .IDX_W(IDX_W), .RA_IDX(RA_IDX)) u_route (
        .kind     (kind_e),
        .cond_hit (cond_hit),
        .seq_pc   (seq_pc),
        .br_tgt   (br_tgt),
        .jmp_tgt  (jmp_tgt),
        .ind_tgt  (ind_tgt),
        .link_rd  (in_link_rd),
        .nxt_pc   (nxt_pc),
        .take     (take),
        .lwe      (lwe),
        .ldst     (ldst)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_next_pc  <= '0;
            out_taken    <= 1'b0;
            out_link_we  <= 1'b0;
            out_link_dst <= '0;
            out_link_val <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_next_pc  <= nxt_pc;
                out_taken    <= take;
                out_link_we  <= lwe;
                out_link_dst <= ldst;
                out_link_val <= lwe ? link_val : '0;
            end
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int TGT_W  = 26,
    parameter int IDX_W  = 5,
    parameter int RA_IDX = 31
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        in_kind,
    input logic [XLEN-1:0]   in_pc,
    input logic [XLEN-1:0]   in_opa,
    input logic [XLEN-1:0]   in_opb,
    input logic              out_valid,
    input logic [XLEN-1:0]   out_next_pc,
    input logic              out_taken,
    input logic              out_link_we,
    input logic [IDX_W-1:0]  out_link_dst,
    input logic [XLEN-1:0]   out_link_val
);

    localparam int REGION_W = XLEN - TGT_W - 2;

    logic [XLEN-1:0]     pc_plus4;
    logic [XLEN-1:0]     pc_plus8;
    logic [REGION_W-1:0] region_now;
    logic                opnd_same;
    logic                lnk_branch;
    logic                abs_jump;

    assign pc_plus4   = in_pc + XLEN'(4);
    assign pc_plus8   = in_pc + XLEN'(8);
    assign region_now = pc_plus4[XLEN-1 -: REGION_W];
    assign opnd_same  = (in_opa == in_opb);
    assign lnk_branch = (in_kind == K_LTZ_LNK) || (in_kind == K_GEZ_LNK);
    assign abs_jump   = (in_kind == K_JMP) || (in_kind == K_JMP_LNK);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r1_equal_taken: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == K_EQ) |=> (out_taken == $past(opnd_same)));

    a_r3_fallthrough_seq: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_taken || out_next_pc == $past(pc_plus4)));

    a_r4_region_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && abs_jump) |=> (out_next_pc[XLEN-1 -: REGION_W] == $past(region_now)));

    a_r7_link_always: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lnk_branch) |=> (out_link_we && out_link_dst == IDX_W'(RA_IDX)));

    a_r5_link_value: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_link_we || out_link_val == $past(pc_plus8)));

    a_r10_dst_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_link_we |-> (out_link_dst == '0));

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W), .IDX_W(IDX_W), .RA_IDX(RA_IDX)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_pc        (in_pc),
    .in_opa       (in_opa),
    .in_opb       (in_opb),
    .out_valid    (out_valid),
    .out_next_pc  (out_next_pc),
    .out_taken    (out_taken),
    .out_link_we  (out_link_we),
    .out_link_dst (out_link_dst),
    .out_link_val (out_link_val)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;

    typedef struct packed {
        logic [31:0] npc;
        logic        tk;
        logic        we;
        logic [4:0]  dst;
        logic [31:0] lv;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_kind = '0;
    logic [31:0] in_pc = '0, in_opa = '0, in_opb = '0;
    logic [15:0] in_off = '0;
    logic [25:0] in_tgt = '0;
    logic [4:0]  in_link_rd = '0;
    logic        out_valid, out_taken, out_link_we;
    logic [31:0] out_next_pc, out_link_val;
    logic [4:0]  out_link_dst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_pc(in_pc), .in_opa(in_opa), .in_opb(in_opb), .in_off(in_off),
        .in_tgt(in_tgt), .in_link_rd(in_link_rd), .out_valid(out_valid),
        .out_next_pc(out_next_pc), .out_taken(out_taken),
        .out_link_we(out_link_we), .out_link_dst(out_link_dst),
        .out_link_val(out_link_val)
    );

    function automatic exp_t model(input logic [3:0] k, input logic [31:0] pc,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [15:0] off, input logic [25:0] tg,
                                   input logic [4:0] rd);
        exp_t e;
        logic [31:0] seq, tgt;
        seq = pc + 32'd4;
        tgt = seq + {{14{off[15]}}, off, 2'b00};
        e.tk = 1'b0; e.we = 1'b0; e.dst = 5'd0; e.lv = 32'd0;
        case (k)
            4'd1:       e.tk = (a == b);
            4'd2:       e.tk = (a != b);
            4'd3:       e.tk = ($signed(a) <= 0);
            4'd4:       e.tk = ($signed(a) > 0);
            4'd5, 4'd7: e.tk = ($signed(a) < 0);
            4'd6, 4'd8: e.tk = ($signed(a) >= 0);
            4'd9, 4'd10: begin e.tk = 1'b1; tgt = {seq[31:28], tg, 2'b00}; end
            4'd11, 4'd12: begin e.tk = 1'b1; tgt = a; end
            default:    e.tk = 1'b0;
        endcase
        if (k == 4'd7 || k == 4'd8 || k == 4'd10) begin e.we = 1'b1; e.dst = 5'd31; end
        if (k == 4'd12) begin e.we = 1'b1; e.dst = rd; end
        if (e.we) e.lv = pc + 32'd8;
        e.npc = e.tk ? tgt : seq;
        return e;
    endfunction

    task automatic send(input string tag, input logic [3:0] k, input logic [31:0] pc,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] off,
                        input logic [25:0] tg, input logic [4:0] rd);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_pc = pc; in_opa = a; in_opb = b;
        in_off = off; in_tgt = tg; in_link_rd = rd;
        exp_q.push_back(model(k, pc, a, b, off, tg, rd));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected result actual=valid expected=idle");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_next_pc !== e.npc || out_taken !== e.tk || out_link_we !== e.we ||
                    out_link_dst !== e.dst || (e.we && out_link_val !== e.lv)) begin
                    errors++;
                    $display("FAIL %s actual npc=%h tk=%b we=%b dst=%0d lv=%h expected npc=%h tk=%b we=%b dst=%0d lv=%h",
                             t, out_next_pc, out_taken, out_link_we, out_link_dst, out_link_val,
                             e.npc, e.tk, e.we, e.dst, e.lv);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        checks++;
        if (out_valid !== 1'b0 || out_next_pc !== 32'd0 || out_taken !== 1'b0 ||
            out_link_we !== 1'b0 || out_link_dst !== 5'd0 || out_link_val !== 32'd0) begin
            errors++;
            $display("FAIL R9 reset actual valid=%b npc=%h expected valid=0 npc=0", out_valid, out_next_pc);
        end

        // R1: equality branches
        send("R1", 4'd1, 32'h0000_1000, 32'd7, 32'd7, 16'h0010, 26'd0, 5'd0);
        send("R1", 4'd1, 32'h0000_1000, 32'd7, 32'd8, 16'h0010, 26'd0, 5'd0);
        send("R1", 4'd2, 32'h0000_2000, 32'd7, 32'd8, 16'h0004, 26'd0, 5'd0);
        send("R1", 4'd2, 32'h0000_2000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0004, 26'd0, 5'd0);
        // R2: signed zero tests
        send("R2", 4'd3, 32'h0000_3000, 32'd0, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd3, 32'h0000_3000, 32'd1, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd4, 32'h0000_3000, 32'd0, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd4, 32'h0000_3000, 32'h7FFF_FFFF, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd5, 32'h0000_3000, 32'h8000_0000, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd5, 32'h0000_3000, 32'd0, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd6, 32'h0000_3000, 32'd0, 32'd0, 16'h0008, 26'd0, 5'd0);
        send("R2", 4'd6, 32'h0000_3000, 32'hFFFF_FFFB, 32'd0, 16'h0008, 26'd0, 5'd0);
        // R3: offset extremes and address wrap
        send("R3", 4'd1, 32'h0000_4000, 32'd0, 32'd0, 16'hFFFF, 26'd0, 5'd0);
        send("R3", 4'd1, 32'h0000_4000, 32'd0, 32'd0, 16'h7FFF, 26'd0, 5'd0);
        send("R3", 4'd1, 32'h0000_4000, 32'd0, 32'd0, 16'h8000, 26'd0, 5'd0);
        send("R3", 4'd2, 32'hFFFF_FFFC, 32'd1, 32'd1, 16'h0100, 26'd0, 5'd0);
        // R4: absolute jump, including a region crossing by PC+4
        send("R4", 4'd9, 32'h1234_5678, 32'd0, 32'd0, 16'd0, 26'h3FF_FFFF, 5'd0);
        send("R4", 4'd9, 32'hAFFF_FFFC, 32'd0, 32'd0, 16'd0, 26'h000_0010, 5'd0);
        // R5: jump with link
        send("R5", 4'd10, 32'h4000_0100, 32'd0, 32'd0, 16'd0, 26'h012_3456, 5'd0);
        // R6: register-indirect
        send("R6", 4'd11, 32'h0000_5000, 32'hDEAD_BEE0, 32'd0, 16'd0, 26'd0, 5'd9);
        send("R6", 4'd12, 32'h0000_5000, 32'h0040_0020, 32'd0, 16'd0, 26'd0, 5'd5);
        send("R6", 4'd12, 32'h0000_6000, 32'h0040_0040, 32'd0, 16'd0, 26'd0, 5'd31);
        // R7: linking branches, taken and not taken
        send("R7", 4'd7, 32'h0000_7000, 32'd3, 32'd0, 16'h0020, 26'd0, 5'd0);
        send("R7", 4'd7, 32'h0000_7000, 32'hFFFF_FFFF, 32'd0, 16'h0020, 26'd0, 5'd0);
        send("R7", 4'd8, 32'h0000_7100, 32'h8000_0000, 32'd0, 16'hFFF0, 26'd0, 5'd0);
        send("R7", 4'd8, 32'h0000_7100, 32'd0, 32'd0, 16'hFFF0, 26'd0, 5'd0);
        // R8: sequential and unused kinds
        send("R8", 4'd0, 32'h0000_8000, 32'd1, 32'd1, 16'h0040, 26'h155_5555, 5'd3);
        send("R8", 4'd14, 32'h0000_8000, 32'd1, 32'd1, 16'h0040, 26'h155_5555, 5'd3);
        send("R8", 4'd15, 32'hFFFF_FFFC, 32'd0, 32'd0, 16'h0040, 26'd0, 5'd3);
        // R10: jump without link leaves the destination at zero
        send("R10", 4'd11, 32'h0000_9000, 32'h0000_0100, 32'd0, 16'd0, 26'd0, 5'd17);

        // R9: idle gap gives no result
        idle();
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 idle actual=%b expected=0", out_valid);
        end
        send("R9", 4'd1, 32'h0000_A000, 32'd2, 32'd2, 16'h0001, 26'd0, 5'd0);
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule